// File: doc/BRIEF.md
# Synchronous Burst Write Port

This block is the device side of a clocked burst write port for a pseudo-static memory with a 16-bit data path. A host opens a burst by pulling chip select, address-valid and write-enable low together on a rising clock edge. The port then latches the start address and counts a programmable number of clocks. After that it stores one data word per clock into a small internal word array, with each byte lane gated by its own active-low lane strobe.

A handshake output tells the host when data is being taken. It is driven low while the port is not yet accepting data. It goes high one clock before the first word is stored. It stays high until chip select is released, and it is driven only while chip select is low. A burst ends after a fixed number of words, or earlier when the host raises chip select. The early end drops every word not yet stored. A second address-valid pulse during a burst has no effect and raises a one-cycle flag. A watchdog flags the case where early-ended bursts keep coming for too long with no completed burst between them.

A read port for the stored words lets the surrounding logic and the bench see what was written.

Top module: `bwr_slave_port`

## Requirements
- R1: A burst starts on the first rising edge at which `chip_sel_n`, `addr_valid_n` and `wr_en_n` are all low while the port is idle, and `busy_o` goes high after that edge. An edge with `wr_en_n` high starts nothing.
- R2: With a latency setting L from 2 to 15 on `lat_cfg_i`, word 0 is stored at the L-th rising edge after the start edge. Words 1 to 3 are stored on the next consecutive edges. Keeping `addr_valid_n` low for extra edges after the start does not shift this timing.
- R3: `hold_oe` is high while `chip_sel_n` is low. It drops in the same cycle that `chip_sel_n` goes high, before any clock edge.
- R4: `hold_o` is low from the start of a burst until the edge L-1 after the start edge, and high after that edge. After a burst that completes normally it stays high until `chip_sel_n` goes high.
- R5: Word i of a burst (i = 0 to 3) is stored at an address that keeps the upper `AW-2` bits of the start address. Its lower two bits are the start address's lower two bits plus i, modulo 4.
- R6: `lo_byte_n` low writes `data_i[7:0]` and `hi_byte_n` low writes `data_i[15:8]`. A lane held high leaves that byte of the stored word unchanged.
- R7: After the fourth word is stored, the port is idle: `busy_o` is low.
- R8: `chip_sel_n` high at a rising edge during a burst ends the burst at that edge. No word is stored at that edge or later in that burst, and the port is idle afterwards.
- R9: A new falling edge of `addr_valid_n`, sampled while busy with `chip_sel_n` low, is ignored: the running burst keeps its address and timing. `overlap_err_o` is high for exactly the one cycle after that edge.
- R10: `stop_err_o` is set, and held until reset, when an early-ended burst (R8) happens at least `STOP_LIMIT` cycles after the first early end of a run. A normally completed burst ends such a run. Early ends that come closer together, or after a completed burst, leave it low.
- R11: After reset, `busy_o`, `hold_o`, `overlap_err_o` and `stop_err_o` are low. With `chip_sel_n` high, `hold_oe` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lat_cfg_i | input | LW | Write latency in clocks (values below 2 act as 2) |
| chip_sel_n | input | 1 | Active-low select; high during a burst ends it early |
| addr_valid_n | input | 1 | Active-low start-address strobe |
| wr_en_n | input | 1 | Active-low write request, sampled at burst start |
| lo_byte_n | input | 1 | Active-low enable for the low data byte |
| hi_byte_n | input | 1 | Active-low enable for the high data byte |
| addr_i | input | AW | Burst start address |
| data_i | input | 16 | Write data |
| hold_o | output | 1 | Handshake level: low = not accepting, high = accepting |
| hold_oe | output | 1 | Drive enable for hold_o (low = high impedance) |
| busy_o | output | 1 | A burst is in progress |
| overlap_err_o | output | 1 | One-cycle pulse on an ignored start during a burst |
| stop_err_o | output | 1 | Sticky early-end watchdog error |
| peek_addr_i | input | AW | Read address into the word array |
| peek_data_o | output | 16 | Stored word at peek_addr_i |

## Verification
The hardest case to reach from the ports is the watchdog. It needs a run of early-ended bursts that stays open for longer than the limit with no completed burst in between. It also needs the opposite case, where a completed burst closes the run and clears the error. The stimulus first ends a burst early, then runs a full burst, then idles past the limit and ends another burst early, and expects no error. It then idles past the limit again and ends a third burst early, and expects the error. Early ends are placed after a chosen number of stored words. The scoreboard then reads back the discarded addresses and expects their earlier contents. A start pulse is also placed inside the latency window to show that it is ignored.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } bwr_state_e;
endpackage

// File: rtl/bwr_lat_cnt.sv
module bwr_lat_cnt #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [LW-1:0] cnt_o
);
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = LW'(1);
    else if (inc_i) cnt_d = cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bwr_addr_gen.sv
module bwr_addr_gen #(
  parameter int AW = 4,
  parameter int BL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int BW = $clog2(BL);

  logic [AW-1:0] base_q;
  logic [BW-1:0] beat_q, beat_d;
  logic [BW-1:0] low_sum;

  always_comb begin
    beat_d = beat_q;
    if (load_i)      beat_d = '0;
    else if (step_i) beat_d = beat_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      if (load_i) base_q <= base_i;
      beat_q <= beat_d;
    end
  end

  assign low_sum = base_q[BW-1:0] + beat_q;
  assign addr_o  = {base_q[AW-1:BW], low_sum};
  assign last_o  = (beat_q == BW'(BL - 1));
endmodule

// File: rtl/bwr_stop_wdog.sv
module bwr_stop_wdog #(
  parameter int STOP_LIMIT = 313
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic done_i,
  output logic err_o
);
  localparam int CW = $clog2(STOP_LIMIT + 1);

  logic          run_q, run_d;
  logic [CW-1:0] age_q, age_d;
  logic          err_q, err_d;

  always_comb begin
    run_d = run_q;
    age_d = age_q;
    err_d = err_q;
    if (done_i) begin
      run_d = 1'b0;
      age_d = '0;
    end else if (stop_i) begin
      if (run_q && (age_q >= CW'(STOP_LIMIT))) err_d = 1'b1;
      if (!run_q) age_d = '0;
      run_d = 1'b1;
    end else if (run_q && (age_q < CW'(STOP_LIMIT))) begin
      age_d = age_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      age_q <= '0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      age_q <= age_d;
      err_q <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/bwr_store.sv
module bwr_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [DW/8-1:0] lane_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr_q [DEPTH];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we_i && lane_en_i[b]) arr_q[waddr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o = arr_q[raddr_i];
endmodule

// File: rtl/bwr_slave_port.sv
module bwr_slave_port
  import bwr_pkg::*;
#(
  parameter int AW         = 4,
  parameter int LW         = 4,
  parameter int BL         = 4,
  parameter int STOP_LIMIT = 313
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lat_cfg_i,
  input  logic          chip_sel_n,
  input  logic          addr_valid_n,
  input  logic          wr_en_n,
  input  logic          lo_byte_n,
  input  logic          hi_byte_n,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  output logic          hold_o,
  output logic          hold_oe,
  output logic          busy_o,
  output logic          overlap_err_o,
  output logic          stop_err_o,
  input  logic [AW-1:0] peek_addr_i,
  output logic [15:0]   peek_data_o
);
  localparam int DW = 16;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  bwr_state_e    state_q, state_d;
  logic          adv_q, rdy_q, rdy_d, ovl_q;
  logic          cs_act, adv_act;
  logic          start, abort, overlap, capture, done;
  logic [LW-1:0] lat_eff, lat_cnt;
  logic          lat_hit;
  logic [AW-1:0] wr_addr;
  logic          last_beat;

  assign cs_act  = !chip_sel_n;
  assign adv_act = !addr_valid_n;
  assign lat_eff = (lat_cfg_i < LW'(2)) ? LW'(2) : lat_cfg_i;
  assign lat_hit = (lat_cnt == lat_eff - LW'(1));

  assign start   = (state_q == ST_IDLE) && cs_act && adv_act && !wr_en_n;
  assign abort   = (state_q != ST_IDLE) && !cs_act;
  assign overlap = (state_q != ST_IDLE) && cs_act && adv_act && !adv_q;
  assign capture = (state_q == ST_DATA) && cs_act;
  assign done    = capture && last_beat;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LAT;
      ST_LAT: begin
        if (abort)        state_d = ST_IDLE;
        else if (lat_hit) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (abort || last_beat) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdy_d = rdy_q;
    if (start || !cs_act)                   rdy_d = 1'b0;
    else if ((state_q == ST_LAT) && lat_hit) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      adv_q   <= 1'b0;
      rdy_q   <= 1'b0;
      ovl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      adv_q   <= adv_act;
      rdy_q   <= rdy_d;
      ovl_q   <= overlap;
    end
  end

  bwr_lat_cnt #(.LW(LW)) u_lat (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (start),
    .inc_i  ((state_q == ST_LAT) && !lat_hit),
    .cnt_o  (lat_cnt)
  );

  bwr_addr_gen #(.AW(AW), .BL(BL)) u_addr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (start),
    .base_i (addr_i),
    .step_i (capture),
    .addr_o (wr_addr),
    .last_o (last_beat)
  );

  bwr_store #(.AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .we_i      (capture),
    .lane_en_i ({!hi_byte_n, !lo_byte_n}),
    .waddr_i   (wr_addr),
    .wdata_i   (data_i),
    .raddr_i   (peek_addr_i),
    .rdata_o   (peek_data_o)
  );

  bwr_stop_wdog #(.STOP_LIMIT(STOP_LIMIT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .stop_i (abort),
    .done_i (done),
    .err_o  (stop_err_o)
  );

  assign hold_oe       = cs_act;
  assign hold_o        = rdy_q && !((state_q == ST_IDLE) && adv_act);
  assign busy_o        = (state_q != ST_IDLE);
  assign overlap_err_o = ovl_q;
endmodule

// File: rtl/bwr_slave_port_chk.sv
module bwr_slave_port_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_sel_n,
  input logic addr_valid_n,
  input logic wr_en_n,
  input logic busy_o,
  input logic hold_o,
  input logic overlap_err_o,
  input logic stop_err_o
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !chip_sel_n && !addr_valid_n && !wr_en_n) |=> busy_o);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && chip_sel_n) |=> !busy_o);

  // R4
  wait_low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> !hold_o);

  // R9
  ovl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err_o |-> $past(busy_o));

  // R10
  stop_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_err_o) |-> $past(busy_o && chip_sel_n));
endmodule

bind bwr_slave_port bwr_slave_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_i_n),
  .chip_sel_n    (chip_sel_n),
  .addr_valid_n  (addr_valid_n),
  .wr_en_n       (wr_en_n),
  .busy_o        (busy_o),
  .hold_o        (hold_o),
  .overlap_err_o (overlap_err_o),
  .stop_err_o    (stop_err_o)
);

// File: tb/bwr_slave_port_test.sv
`timescale 1ns/1ps
module bwr_slave_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lat_cfg;
  logic        cs_n, adv_n, we_n, lo_n, hi_n;
  logic [3:0]  addr, peek_addr;
  logic [15:0] data, peek_data;
  logic        hold_o, hold_oe, busy, ovl_err, stop_err;

  int checks = 0;
  int fails  = 0;

  logic [15:0] model [16];
  logic [3:0]  qa [$];
  logic [15:0] qd [$];
  string       qt [$];
  event        sb_go, sb_done;

  always #4 clk = ~clk;

  bwr_slave_port uut (
    .clk(clk), .rst_n(rst_n), .lat_cfg_i(lat_cfg),
    .chip_sel_n(cs_n), .addr_valid_n(adv_n), .wr_en_n(we_n),
    .lo_byte_n(lo_n), .hi_byte_n(hi_n), .addr_i(addr), .data_i(data),
    .hold_o(hold_o), .hold_oe(hold_oe), .busy_o(busy),
    .overlap_err_o(ovl_err), .stop_err_o(stop_err),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] a, input logic [15:0] d, input string t);
    qa.push_back(a); qd.push_back(d); qt.push_back(t);
  endtask

  // monitor: drains the scoreboard through the read port
  initial begin
    forever begin
      @(sb_go);
      while (qa.size() > 0) begin
        logic [3:0]  a;
        logic [15:0] d;
        string       t;
        a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
        peek_addr = a;
        #1;
        chk(peek_data === d, t, peek_data, d);
      end
      -> sb_done;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; adv_n = 1'b1; we_n = 1'b1;
    lo_n = 1'b0; hi_n = 1'b0; addr = '0; data = '0; lat_cfg = 4'd5; peek_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11
    chk(busy === 1'b0 && hold_o === 1'b0 && hold_oe === 1'b0, "R11 idle/hold",
        {busy, hold_o, hold_oe}, 3'b000);
    chk(ovl_err === 1'b0 && stop_err === 1'b0, "R11 flags", {ovl_err, stop_err}, 2'b00);
  endtask

  // nbeats = words stored before chip select is raised (4 = full burst)
  task automatic burst(input logic [3:0] base, input int lat, input int nbeats,
                       input logic lon, input logic hin, input bit adv_hold,
                       input bit ovl, input logic [15:0] seed);
    logic [3:0]  a;
    logic [15:0] w;
    @(negedge clk);
    lat_cfg = 4'(lat); cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0;
    addr = base; lo_n = lon; hi_n = hin;
    #1;
    chk(hold_oe === 1'b1 && hold_o === 1'b0, "R3 R4 start drive low", {hold_oe, hold_o}, 2'b10);
    @(negedge clk);
    chk(busy === 1'b1, "R1 start", busy, 1'b1);
    if (!adv_hold) adv_n = 1'b1;
    for (int k = 1; k <= lat - 2; k++) begin
      @(negedge clk);
      chk(hold_o === 1'b0 && busy === 1'b1, "R4 low in latency", {hold_o, busy}, 2'b01);
      adv_n = 1'b1;
      if (ovl && k == 1) begin
        adv_n = 1'b0;
        addr  = base ^ 4'h4;
      end
      if (ovl && k == 2) chk(ovl_err === 1'b1, "R9 overlap pulse", ovl_err, 1'b1);
      if (ovl && k == 3) chk(ovl_err === 1'b0, "R9 pulse length", ovl_err, 1'b0);
    end
    @(negedge clk);
    adv_n = 1'b1;
    chk(hold_o === 1'b1, "R4 high from L-1", hold_o, 1'b1);
    for (int i = 0; i < 4; i++) begin
      a = {base[3:2], base[1:0] + 2'(i)};
      if (i < nbeats) begin
        w = seed + 16'(i) * 16'h1111;
        data = w;
        if (!lon) model[a][7:0]  = w[7:0];
        if (!hin) model[a][15:8] = w[15:8];
        push(a, model[a], (lon || hin) ? "R6 lanes" : "R2 R5 word");
        @(negedge clk);
      end else begin
        if (i == nbeats) begin
          cs_n = 1'b1;
          #1;
          chk(hold_oe === 1'b0, "R3 float on stop", hold_oe, 1'b0);
          @(negedge clk);
          chk(busy === 1'b0, "R8 idle after stop", busy, 1'b0);
        end
        push(a, model[a], "R8 discarded");
      end
    end
    if (nbeats >= 4) begin
      chk(busy === 1'b0, "R7 idle after length", busy, 1'b0);
      chk(hold_o === 1'b1 && hold_oe === 1'b1, "R4 stays high", {hold_o, hold_oe}, 2'b11);
      cs_n = 1'b1;
      #1;
      chk(hold_oe === 1'b0, "R3 float", hold_oe, 1'b0);
    end
    @(negedge clk);
    we_n = 1'b1; lo_n = 1'b0; hi_n = 1'b0;
    -> sb_go;
    @(sb_done);
  endtask

  initial begin
    #1200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    do_reset();
    burst(4'h0, 5, 4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
    burst(4'h4, 5, 4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0F0F);
    burst(4'h6, 3, 4, 1'b0, 1'b0, 1'b1, 1'b0, 16'hA5C3);  // R2 long address strobe
    burst(4'h1, 5, 4, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7E81);  // R6 low lane only
    burst(4'h2, 2, 4, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC018);  // R6 high lane only
    burst(4'h8, 5, 4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222);
    burst(4'h9, 5, 4, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3C3C);  // R9 overlap in latency
    // R1: write enable high starts nothing
    @(negedge clk);
    cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 no start without write", busy, 1'b0);
    cs_n = 1'b1; adv_n = 1'b1;
    // R8 early end, then R10 run closed by a full burst
    burst(4'h4, 5, 2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5A5A);
    chk(stop_err === 1'b0, "R10 first stop", stop_err, 1'b0);
    burst(4'h0, 5, 4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h6161);
    repeat (400) @(negedge clk);
    burst(4'h8, 4, 1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7070);
    chk(stop_err === 1'b0, "R10 run closed", stop_err, 1'b0);
    repeat (400) @(negedge clk);
    burst(4'h0, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk(stop_err === 1'b1, "R10 late repeat stop", stop_err, 1'b1);
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule